// File: doc/BRIEF.md
# Clock-Calendar Update Engine

This block keeps the time of day and a two-digit-year calendar as seven bytes: seconds, minutes, hours, day of week, day of month, month and year. A prescaler counts a base-rate strobe into one-second steps. Before each step a status flag warns the host that the fields are about to change. At the step a small state machine advances the fields, compares the new time against three alarm bytes, and then refreshes a host-visible user copy. Each field byte is held in the encoding the host selects at run time: packed BCD or plain binary. Hours run in either 24-hour form or 12-hour form. In 12-hour form bit 7 of the hours byte marks PM. An optional daylight-saving rule moves the clock forward one hour in spring and back one hour in autumn.

The host loads time and alarm bytes through a simple indexed write port and reads the user copy through an indexed read port. A hold input freezes the user copy so that the host can read a consistent snapshot. While hold is set the internal fields keep advancing.

The state machine has five states. ST_IDLE waits. It moves to ST_PEND when the prescaler enters the pre-update window, or straight to ST_ADV on the update step. ST_PEND moves to ST_ADV on the update step, or back to ST_IDLE if the prescaler is stopped. ST_ADV loads the advanced fields and moves to ST_CMP. ST_CMP latches the alarm comparison and moves to ST_XFER. ST_XFER refreshes the user copy, pulses the outputs and returns to ST_IDLE.

Top module: `rtc_upd_engine`

## Requirements
- R1: After reset the user copy reads sec=00, min=00, hour=00, day-of-week=01, date=01, month=01, year=00. All three alarm bytes are 00. The outputs `uip`, `upd_done` and `alarm_hit` are 0.
- R2: In BCD with 24-hour form, 23:59:59 on a Saturday (day-of-week 07), the 31st of month 12 in year 99, advances to 00:00:00, day-of-week 01, the 1st of month 01, year 00. Day of week runs 1 to 7, where 1 is Sunday.
- R3: When `bin_fmt`=1, every byte is plain binary, for example seconds 3Bh means 59. In binary, February of a year divisible by 4 has 29 days, so Feb 28 of year 18h (24) advances to Feb 29.
- R4: Month lengths: months 4, 6, 9 and 11 have 30 days. February has 28 days when the year is not divisible by 4. All other months have 31 days. The last day of a month rolls over to day 1 of the next month.
- R5: When `hr24`=0, the hours byte holds 1 to 12 with bit 7 set for PM. 11:59:59 PM rolls to 12 AM together with a date increment. 11:59:59 AM rolls to 12 PM. 12:59:59 AM rolls to 1 AM.
- R6: After each advance the new seconds, minutes and hours are compared with alarm bytes 0, 1 and 2. An alarm byte whose bits 7:6 are both 1 matches any value. `alarm_hit` pulses on the same cycle as `upd_done` only when all three bytes match.
- R7: `uip` rises when the prescaler count reaches DIV_COUNT-UIP_LEAD and stays high until the update ends. It falls on the same edge that raises `upd_done`. `upd_done` lasts one cycle.
- R8: While `xfer_hold`=1, the user copy is not refreshed, the internal fields still advance on every update, and `uip` reads 0.
- R9: When `dst_en`=1, on a Sunday in month 4 with date 1 to 7, the step after 01:59:59 gives 03:00:00.
- R10: When `dst_en`=1, on a Sunday in month 10 with date 25 or later, the first step after 01:59:59 gives 01:00:00 and sets a one-shot flag. The next pass through 01:59:59 gives 02:00:00. Loading the time does not clear the flag. A day rollover clears it.
- R11: The prescaler runs only while `osc_ctl[2:1]`=01. In any other setting it is held at DIV_COUNT/2. With `base_tick` high every cycle, `upd_done` therefore appears DIV_COUNT/2+3 clock cycles after the prescaler is enabled.
- R12: A write with `load_sel` 0 to 6 sets the seconds, minutes, hours, day-of-week, date, month or year byte. A write with `load_sel` 7 to 9 sets the seconds, minutes or hours alarm byte. Writes are accepted only in ST_IDLE and ST_PEND. `rd_sel` 0 to 6 reads the user copy in the same field order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | Base-rate strobe counted by the prescaler |
| osc_ctl | input | 3 | Prescaler control, runs when bits 2:1 are 01 |
| bin_fmt | input | 1 | 1 selects binary bytes, 0 selects BCD |
| hr24 | input | 1 | 1 selects 24-hour form, 0 selects 12-hour form with a PM bit |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| xfer_hold | input | 1 | Freezes the user copy and masks `uip` |
| load_en | input | 1 | Write strobe for time and alarm bytes |
| load_sel | input | 4 | Write index, 0 to 6 for fields and 7 to 9 for alarms |
| load_data | input | 8 | Write data |
| rd_sel | input | 3 | User-copy read index |
| rd_data | output | 8 | User-copy byte selected by `rd_sel` |
| uip | output | 1 | Update pending or in progress |
| upd_done | output | 1 | One-cycle pulse at the end of an update |
| alarm_hit | output | 1 | One-cycle pulse when the new time matches the alarm |

## Verification
Four properties hold on every cycle. `uip` stays low while hold is set. The user copy never changes while hold is set. `upd_done` is a single-cycle pulse that is preceded by `uip` and coincides with its fall. `alarm_hit` never occurs without `upd_done`. The calendar arithmetic can only be shown by the bench's scenarios: minute, hour, day, month and year carries in both encodings; leap February and the 30-day months; the 12-hour PM transitions; the daylight-saving jumps and their one-shot flag; the alarm don't-care code; and the half-second delay before the first update.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int NUM_ALARMS = 3;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DOM  = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef logic [NUM_FIELDS-1:0][7:0] fields_t;
    typedef logic [NUM_ALARMS-1:0][7:0] alarms_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_ADV,
        ST_CMP,
        ST_XFER
    } upd_state_e;

    // Byte in the selected encoding to a plain value.
    function automatic logic [6:0] code_to_val(input logic [7:0] code, input logic bin);
        logic [6:0] tens;
        tens = 7'(code[7:4]);
        return bin ? code[6:0] : 7'(tens * 7'd10 + 7'(code[3:0]));
    endfunction

    // Plain value (0..99) to a byte in the selected encoding.
    function automatic logic [7:0] val_to_code(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // Hours byte to 0..23.
    function automatic logic [4:0] hour_to_24(input logic [7:0] code, input logic bin,
                                              input logic h24);
        logic [6:0] h;
        if (h24) return 5'(code_to_val(code, bin));
        h = code_to_val({1'b0, code[6:0]}, bin);
        if (h == 7'd12) return code[7] ? 5'd12 : 5'd0;
        return code[7] ? 5'(h + 7'd12) : 5'(h);
    endfunction

    // 0..23 to an hours byte.
    function automatic logic [7:0] hour_from_24(input logic [4:0] h, input logic bin,
                                                input logic h24);
        if (h24)        return val_to_code(7'(h), bin);
        if (h == 5'd0)  return val_to_code(7'd12, bin);
        if (h < 5'd12)  return val_to_code(7'(h), bin);
        if (h == 5'd12) return 8'h80 | val_to_code(7'd12, bin);
        return 8'h80 | val_to_code(7'(h - 5'd12), bin);
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
        if (mon == 7'd2)  return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
        if (mon == 7'd4 || mon == 7'd6 || mon == 7'd9 || mon == 7'd11) return 7'd30;
        return 7'd31;
    endfunction

endpackage

// File: rtl/rtc_upd_divider.sv
module rtc_upd_divider #(
    parameter int DIV_COUNT = 16,
    parameter int UIP_LEAD  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic [2:0] osc_ctl,
    output logic       run,
    output logic       pre,
    output logic       fire
);
    localparam int CW = $clog2(DIV_COUNT);
    localparam logic [CW-1:0] HALF   = CW'(DIV_COUNT / 2);
    localparam logic [CW-1:0] LAST   = CW'(DIV_COUNT - 1);
    localparam logic [CW-1:0] PRE_AT = CW'(DIV_COUNT - UIP_LEAD);

    logic [CW-1:0] cnt_q;
    logic          osc_lsb_unused;

    assign osc_lsb_unused = osc_ctl[0];
    assign run  = (osc_ctl[2:1] == 2'b01);
    assign pre  = run && (cnt_q >= PRE_AT);
    assign fire = run && base_tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= HALF;
        end else if (!run) begin
            cnt_q <= HALF;
        end else if (base_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_upd_advance.sv
module rtc_upd_advance
    import rtc_upd_pkg::*;
(
    input  fields_t cur,
    input  logic    bin_fmt,
    input  logic    hr24,
    input  logic    dst_en,
    input  logic    fall_done,
    output fields_t nxt,
    output logic    fall_take,
    output logic    day_roll
);
    logic [6:0] s, m, dw, dd, mo, yr, mdays;
    logic [4:0] h;
    logic [6:0] s_n, m_n, dw_n, dd_n, mo_n, yr_n;
    logic [4:0] h_n;
    logic       at_159, spring, fall;

    always_comb begin
        s  = code_to_val(cur[F_SEC], bin_fmt);
        m  = code_to_val(cur[F_MIN], bin_fmt);
        h  = hour_to_24(cur[F_HOUR], bin_fmt, hr24);
        dw = code_to_val(cur[F_DOW], bin_fmt);
        dd = code_to_val(cur[F_DOM], bin_fmt);
        mo = code_to_val(cur[F_MON], bin_fmt);
        yr = code_to_val(cur[F_YEAR], bin_fmt);
        mdays  = month_days(mo, yr);
        at_159 = (h == 5'd1) && (m == 7'd59) && (s == 7'd59);
        spring = dst_en && (mo == 7'd4) && (dw == 7'd1) && (dd <= 7'd7) && at_159;
        fall   = dst_en && (mo == 7'd10) && (dw == 7'd1) && (dd >= 7'd25) && at_159
                 && !fall_done;
    end

    always_comb begin
        s_n = s; m_n = m; h_n = h; dw_n = dw; dd_n = dd; mo_n = mo; yr_n = yr;
        day_roll = 1'b0;
        if (s < 7'd59) begin
            s_n = s + 7'd1;
        end else begin
            s_n = '0;
            if (m < 7'd59) begin
                m_n = m + 7'd1;
            end else begin
                m_n = '0;
                if (h < 5'd23) begin
                    h_n = h + 5'd1;
                end else begin
                    h_n      = '0;
                    day_roll = 1'b1;
                    dw_n     = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
                    if (dd < mdays) begin
                        dd_n = dd + 7'd1;
                    end else begin
                        dd_n = 7'd1;
                        if (mo < 7'd12) begin
                            mo_n = mo + 7'd1;
                        end else begin
                            mo_n = 7'd1;
                            yr_n = (yr >= 7'd99) ? 7'd0 : yr + 7'd1;
                        end
                    end
                end
            end
        end
        if (spring) h_n = 5'd3;
        if (fall)   h_n = 5'd1;
    end

    assign fall_take = fall;

    always_comb begin
        nxt[F_SEC]  = val_to_code(s_n, bin_fmt);
        nxt[F_MIN]  = val_to_code(m_n, bin_fmt);
        nxt[F_HOUR] = hour_from_24(h_n, bin_fmt, hr24);
        nxt[F_DOW]  = val_to_code(dw_n, bin_fmt);
        nxt[F_DOM]  = val_to_code(dd_n, bin_fmt);
        nxt[F_MON]  = val_to_code(mo_n, bin_fmt);
        nxt[F_YEAR] = val_to_code(yr_n, bin_fmt);
    end
endmodule

// File: rtl/rtc_upd_alarm.sv
module rtc_upd_alarm
    import rtc_upd_pkg::*;
(
    input  fields_t cur,
    input  alarms_t alm,
    output logic    match
);
    logic [NUM_ALARMS-1:0] slot_ok;

    // Alarm slots 0..2 line up with the seconds, minutes and hours fields.
    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_slot
        assign slot_ok[g] = (alm[g][7:6] == 2'b11) || (alm[g] == cur[g]);
    end

    assign match = &slot_ok;
endmodule

// File: rtl/rtc_upd_engine.sv
module rtc_upd_engine
    import rtc_upd_pkg::*;
#(
    parameter int DIV_COUNT = 16,
    parameter int UIP_LEAD  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic [2:0] osc_ctl,
    input  logic       bin_fmt,
    input  logic       hr24,
    input  logic       dst_en,
    input  logic       xfer_hold,
    input  logic       load_en,
    input  logic [3:0] load_sel,
    input  logic [7:0] load_data,
    input  logic [2:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       uip,
    output logic       upd_done,
    output logic       alarm_hit
);
    localparam fields_t RESET_TIME = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    localparam logic [3:0] NF = 4'(NUM_FIELDS);
    localparam logic [3:0] NA = 4'(NUM_FIELDS + NUM_ALARMS);

    upd_state_e state_q, state_d;
    fields_t    time_q, user_q, adv_next;
    alarms_t    alarm_q;
    logic       fall_q, fall_take, day_roll;
    logic       run, pre, fire, alarm_match;
    logic       uip_q, done_q, ahit_q, match_q;
    logic [3:0] asel;
    logic       load_ok;

    rtc_upd_divider #(.DIV_COUNT(DIV_COUNT), .UIP_LEAD(UIP_LEAD)) div_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .osc_ctl(osc_ctl),
        .run(run), .pre(pre), .fire(fire)
    );

    rtc_upd_advance adv_i (
        .cur(time_q), .bin_fmt(bin_fmt), .hr24(hr24), .dst_en(dst_en),
        .fall_done(fall_q), .nxt(adv_next), .fall_take(fall_take), .day_roll(day_roll)
    );

    rtc_upd_alarm alm_i (
        .cur(time_q), .alm(alarm_q), .match(alarm_match)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (fire) state_d = ST_ADV;
                     else if (pre) state_d = ST_PEND;
            ST_PEND: if (fire) state_d = ST_ADV;
                     else if (!run) state_d = ST_IDLE;
            ST_ADV:  state_d = ST_CMP;
            ST_CMP:  state_d = ST_XFER;
            ST_XFER: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and user copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uip_q   <= 1'b0;
            done_q  <= 1'b0;
            ahit_q  <= 1'b0;
            match_q <= 1'b0;
            user_q  <= RESET_TIME;
        end else begin
            done_q <= 1'b0;
            ahit_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (fire || pre) uip_q <= 1'b1;
                ST_PEND: if (!fire && !run) uip_q <= 1'b0;
                ST_ADV:  ;
                ST_CMP:  match_q <= alarm_match;
                ST_XFER: begin
                    uip_q  <= 1'b0;
                    done_q <= 1'b1;
                    ahit_q <= match_q;
                    if (!xfer_hold) user_q <= time_q;
                end
                default: ;
            endcase
        end
    end

    // Field and alarm storage
    assign load_ok = load_en && (state_q == ST_IDLE || state_q == ST_PEND);
    assign asel    = load_sel - NF;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q  <= RESET_TIME;
            alarm_q <= '0;
            fall_q  <= 1'b0;
        end else if (state_q == ST_ADV) begin
            time_q <= adv_next;
            if (fall_take)     fall_q <= 1'b1;
            else if (day_roll) fall_q <= 1'b0;
        end else if (load_ok) begin
            if (load_sel < NF)      time_q[load_sel[2:0]] <= load_data;
            else if (load_sel < NA) alarm_q[asel[1:0]]    <= load_data;
        end
    end

    assign rd_data   = (rd_sel < 3'(NUM_FIELDS)) ? user_q[rd_sel] : 8'h00;
    assign uip       = uip_q && !xfer_hold;
    assign upd_done  = done_q;
    assign alarm_hit = ahit_q;
endmodule

// File: rtl/rtc_upd_engine_chk.sv
module rtc_upd_engine_chk
    import rtc_upd_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    xfer_hold,
    input logic    uip,
    input logic    upd_done,
    input logic    alarm_hit,
    input fields_t user_q
);
    // R8: uip is masked while the user copy is held
    p_uip_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_hold |-> !uip);

    // R8: the user copy cannot change while hold is set
    p_user_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_hold |=> $stable(user_q));

    // R7: the update-ended output is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> !upd_done);

    // R7: uip falls on the edge that raises upd_done
    p_uip_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |-> !uip);

    // R7: an update without hold was announced by uip
    p_uip_leads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !xfer_hold && !$past(xfer_hold)) |-> $past(uip));

    // R6: an alarm pulse only comes with an update end
    p_alarm_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_done);
endmodule

bind rtc_upd_engine rtc_upd_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .xfer_hold(xfer_hold), .uip(uip),
    .upd_done(upd_done), .alarm_hit(alarm_hit), .user_q(user_q)
);

// File: tb/rtc_upd_engine_tb_top.sv
`timescale 1ns/1ps
module rtc_upd_engine_tb_top;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b1;
    logic [2:0] osc_ctl = 3'b110;
    logic       bin_fmt = 1'b0, hr24 = 1'b1, dst_en = 1'b0, xfer_hold = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_sel = '0;
    logic [7:0] load_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       uip, upd_done, alarm_hit;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic [55:0] f;
        bit          a;
        bit          u;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    rtc_upd_engine #(.DIV_COUNT(DIV), .UIP_LEAD(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .osc_ctl(osc_ctl),
        .bin_fmt(bin_fmt), .hr24(hr24), .dst_en(dst_en), .xfer_hold(xfer_hold),
        .load_en(load_en), .load_sel(load_sel), .load_data(load_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .uip(uip), .upd_done(upd_done),
        .alarm_hit(alarm_hit)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [55:0] pk(input logic [7:0] s, m, h, dw, dd, mo, yr);
        return {yr, mo, dd, dw, h, m, s};
    endfunction

    // Monitor: pops an expected item on every update end
    logic prev_uip = 1'b0;
    always @(negedge clk) begin
        item_t it;
        logic  uip_now, ah_now;
        uip_now = uip;
        ah_now  = alarm_hit;
        if (rst_n && upd_done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected update end", 1, 0);
            end else begin
                it = sb_q.pop_front();
                for (int i = 0; i < 7; i++) begin
                    rd_sel = 3'(i);
                    #0.2;
                    chk(rd_data == it.f[i*8 +: 8], it.req, $sformatf("field %0d", i),
                        32'(rd_data), 32'(it.f[i*8 +: 8]));
                end
                chk(ah_now == it.a, it.req, "alarm_hit (R6)", 32'(ah_now), 32'(it.a));
                chk(prev_uip == it.u, it.req, "uip before end (R7)", 32'(prev_uip), 32'(it.u));
            end
        end
        prev_uip = uip_now;
    end

    task automatic load(input logic [3:0] sel, input logic [7:0] d);
        @(negedge clk);
        load_en = 1'b1; load_sel = sel; load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic load_time(input logic [7:0] s, m, h, dw, dd, mo, yr);
        load(4'd0, s); load(4'd1, m); load(4'd2, h); load(4'd3, dw);
        load(4'd4, dd); load(4'd5, mo); load(4'd6, yr);
    endtask

    bit hold_uip_seen;

    // Driver: pushes the expectation, starts the prescaler, stops it after one update
    task automatic run_update(input logic [55:0] f, input bit a, input bit u,
                              input string req, output int cyc);
        item_t it;
        it.f = f; it.a = a; it.u = u; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        osc_ctl = 3'b010;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (xfer_hold && uip) hold_uip_seen = 1'b1;
        end while (!upd_done && cyc < 200);
        osc_ctl = 3'b110;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        logic [55:0] rst_exp;
        rst_exp = pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 7; i++) begin
            rd_sel = 3'(i);
            #0.2;
            chk(rd_data == rst_exp[i*8 +: 8], "R1", $sformatf("reset field %0d", i),
                32'(rd_data), 32'(rst_exp[i*8 +: 8]));
        end
        chk(uip == 1'b0 && upd_done == 1'b0 && alarm_hit == 1'b0, "R1", "reset outputs",
            {29'd0, uip, upd_done, alarm_hit}, 0);

        // R12 alarm slots through sel 7..9
        load(4'd7, 8'h45); load(4'd8, 8'h45); load(4'd9, 8'h45);

        // R2 full BCD rollover, R11 first-update delay
        load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        run_update(pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00), 0, 1, "R2 R12", cyc);
        chk(cyc == DIV / 2 + 3, "R11", "cycles to first update end", 32'(cyc), DIV / 2 + 3);

        // R3 binary, leap February
        bin_fmt = 1'b1;
        load_time(8'h3B, 8'h3B, 8'h17, 8'h03, 8'h1C, 8'h02, 8'h18);
        run_update(pk(8'h00, 8'h00, 8'h00, 8'h04, 8'h1D, 8'h02, 8'h18), 0, 1, "R3", cyc);

        // R4 binary, non-leap February
        load_time(8'h3B, 8'h3B, 8'h17, 8'h04, 8'h1C, 8'h02, 8'h17);
        run_update(pk(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h17), 0, 1, "R4", cyc);

        // R5 12-hour BCD: 11:59:59 PM Apr 30 -> 12 AM May 1 (R4 30-day month)
        bin_fmt = 1'b0; hr24 = 1'b0;
        load_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h30, 8'h04, 8'h25);
        run_update(pk(8'h00, 8'h00, 8'h12, 8'h03, 8'h01, 8'h05, 8'h25), 0, 1, "R5 R4", cyc);

        // R5 11:59:59 AM -> 12 PM
        load_time(8'h59, 8'h59, 8'h11, 8'h03, 8'h01, 8'h05, 8'h25);
        run_update(pk(8'h00, 8'h00, 8'h92, 8'h03, 8'h01, 8'h05, 8'h25), 0, 1, "R5", cyc);

        // R5 binary 12:59:59 AM -> 1 AM
        bin_fmt = 1'b1;
        load_time(8'h3B, 8'h3B, 8'h0C, 8'h01, 8'h01, 8'h01, 8'h00);
        run_update(pk(8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h00), 0, 1, "R5", cyc);

        // R9 spring forward
        bin_fmt = 1'b0; hr24 = 1'b1; dst_en = 1'b1;
        load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h05, 8'h04, 8'h25);
        run_update(pk(8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h04, 8'h25), 0, 1, "R9", cyc);

        // R10 fall back once, then pass through
        load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h27, 8'h10, 8'h25);
        run_update(pk(8'h00, 8'h00, 8'h01, 8'h01, 8'h27, 8'h10, 8'h25), 0, 1, "R10", cyc);
        load(4'd0, 8'h59); load(4'd1, 8'h59); load(4'd2, 8'h01);
        run_update(pk(8'h00, 8'h00, 8'h02, 8'h01, 8'h27, 8'h10, 8'h25), 0, 1, "R10", cyc);
        // R10 day rollover clears the one-shot
        load(4'd0, 8'h59); load(4'd1, 8'h59); load(4'd2, 8'h23);
        run_update(pk(8'h00, 8'h00, 8'h00, 8'h02, 8'h28, 8'h10, 8'h25), 0, 1, "R10", cyc);
        load_time(8'h59, 8'h59, 8'h01, 8'h01, 8'h27, 8'h10, 8'h25);
        run_update(pk(8'h00, 8'h00, 8'h01, 8'h01, 8'h27, 8'h10, 8'h25), 0, 1, "R10", cyc);
        dst_en = 1'b0;

        // R6 alarm with don't-care minutes and hours
        load(4'd7, 8'h05); load(4'd8, 8'hC0); load(4'd9, 8'hC0);
        load(4'd0, 8'h04); load(4'd1, 8'h20); load(4'd2, 8'h10);
        run_update(pk(8'h05, 8'h20, 8'h10, 8'h01, 8'h27, 8'h10, 8'h25), 1, 1, "R6", cyc);
        // R6 minute mismatch
        load(4'd8, 8'h21);
        load(4'd0, 8'h04);
        run_update(pk(8'h05, 8'h20, 8'h10, 8'h01, 8'h27, 8'h10, 8'h25), 0, 1, "R6", cyc);
        // R6 full match
        load(4'd8, 8'h20); load(4'd9, 8'h10);
        load(4'd0, 8'h04);
        run_update(pk(8'h05, 8'h20, 8'h10, 8'h01, 8'h27, 8'h10, 8'h25), 1, 1, "R6", cyc);

        // R8 hold: user copy frozen, internal keeps running
        xfer_hold = 1'b1;
        hold_uip_seen = 1'b0;
        load(4'd0, 8'h00); load(4'd1, 8'h00); load(4'd2, 8'h08);
        run_update(pk(8'h05, 8'h20, 8'h10, 8'h01, 8'h27, 8'h10, 8'h25), 0, 0, "R8", cyc);
        chk(!hold_uip_seen, "R8", "uip seen while held", 32'(hold_uip_seen), 0);
        xfer_hold = 1'b0;
        run_update(pk(8'h02, 8'h00, 8'h08, 8'h01, 8'h27, 8'h10, 8'h25), 0, 1, "R8", cyc);

        repeat (5) @(negedge clk);
        chk(sb_q.size() == 0, "R7", "pending expected updates", 32'(sb_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule